// File: doc/BRIEF.md
# Power Supply Sequencing Controller

This block lives in the always-on domain and runs from the slow clock. It brings up the core power domain and brings it back down again. After its own power-on reset it waits for two conditions: the backup supply must be valid and the internal slow oscillator must have settled. It then switches on the core regulator, drives the shutdown-control pin high, and holds the system reset asserted until the core supply reports valid.

While the core runs, the block asserts system reset whenever an enabled supply monitor or brownout detector reports a failure. It releases reset once that failure clears. A software request puts the chip into backup mode in two steps: reset is asserted first, and the regulator is switched off one slow-clock cycle later. From backup mode, a rising edge on any of three kinds of source wakes the chip: the force-wake pin, any of the wake pins, or the clock alarm. A wake runs the full cold-start sequence again.

A programmable timeout flags a core supply that never comes up. A second subsystem reset stays asserted after every power-up.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `reg_en_o`, `shdn_o`, `sys_rst_no`, `sub1_rst_no` and `tmo_flag_o` are all 0.
- R2: The regulator stays off while either `bkup_ok_i` or `osc_ok_i` is low.
- R3: When the later of `bkup_ok_i` and `osc_ok_i` rises, `reg_en_o` and `shdn_o` go high after the third rising clock edge, and `sys_rst_no` stays 0.
- R4: With the regulator on, `sys_rst_no` goes to 1 after the third clock edge following the rise of `core_ok_i`, and never before it.
- R5: While running, an enabled fail input (`io_fail_i` with `io_mon_en_i`=1, or `core_fail_i` with `bod_en_i`=1) drives `sys_rst_no` to 0. Reset is released after the third clock edge once the fail input clears.
- R6: A fail input whose enable bit is 0 has no effect on `sys_rst_no`.
- R7: `sleep_req_i`=1 while running sets `sys_rst_no`=0 at the next edge with `reg_en_o` still 1. At the following edge `reg_en_o` and `shdn_o` go to 0, and they stay 0 until a wake event arrives.
- R8: `sub1_rst_no` is 0 at all times.
- R9: If `core_ok_i` stays low for more than `tmo_limit_i` cycles with the regulator on, `tmo_flag_o` goes to 1 and reset stays asserted. The flag clears when the core supply is accepted.
- R10: In backup mode, a rising edge on `fwake_i`, on any bit of `wkup_i`, or on `alarm_i` wakes the block three edges later. A wake input held steadily high does not wake it.
- R11: A wake repeats the cold start: `reg_en_o`=1, `shdn_o`=1, and `sys_rst_no`=0 until `core_ok_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Always-on power-on reset, active low |
| bkup_ok_i | input | 1 | Backup supply valid (async) |
| osc_ok_i | input | 1 | Slow RC oscillator settled (async) |
| core_ok_i | input | 1 | Core supply valid (async) |
| io_fail_i | input | 1 | I/O supply monitor fail (async) |
| core_fail_i | input | 1 | Core brownout fail (async) |
| io_mon_en_i | input | 1 | Software enable for the I/O monitor fail |
| bod_en_i | input | 1 | Software enable for the brownout fail |
| sleep_req_i | input | 1 | Software request to enter backup mode |
| fwake_i | input | 1 | Force-wake pin (async) |
| wkup_i | input | NWAKE | Wake pins (async) |
| alarm_i | input | 1 | Clock alarm (async) |
| tmo_limit_i | input | TMO_W | Core-valid timeout in cycles |
| reg_en_o | output | 1 | Core regulator enable |
| shdn_o | output | 1 | Shutdown-control pin |
| sys_rst_no | output | 1 | System reset, active low |
| sub1_rst_no | output | 1 | Second subsystem reset, active low |
| tmo_flag_o | output | 1 | Core-valid timeout status |

## Verification
The assertions assume that `bkup_ok_i` and `osc_ok_i` stay high once they have risen, so that every regulator turn-on, including one caused by a wake, can be traced back to both of them. They also assume that the software inputs `sleep_req_i`, `io_mon_en_i` and `bod_en_i` are already synchronous to the slow clock. The stimulus drives every input on the falling edge. It raises the backup supply and the oscillator once and never drops them, and it pulses `sleep_req_i` for exactly one cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_BKUP = 3'd0,
        ST_START     = 3'd1,
        ST_RUN       = 3'd2,
        ST_FAIL      = 3'd3,
        ST_BK_RST    = 3'd4,
        ST_BK_OFF    = 3'd5
    } seq_state_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d_i[i];
                s2_q <= s1_q;
            end
        end
        assign q_o[i] = s2_q;
    end
endmodule

// File: rtl/pwr_wake_edge.sv
module pwr_wake_edge #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic         evt_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    assign evt_o = |(lvl_i & ~prev_q);
endmodule

// File: rtl/pwr_tmo_cnt.sv
module pwr_tmo_cnt #(
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i)                cnt_d = '0;
        else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NWAKE = 4,
    parameter int TMO_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bkup_ok_i,
    input  logic             osc_ok_i,
    input  logic             core_ok_i,
    input  logic             io_fail_i,
    input  logic             core_fail_i,
    input  logic             io_mon_en_i,
    input  logic             bod_en_i,
    input  logic             sleep_req_i,
    input  logic             fwake_i,
    input  logic [NWAKE-1:0] wkup_i,
    input  logic             alarm_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    output logic             reg_en_o,
    output logic             shdn_o,
    output logic             sys_rst_no,
    output logic             sub1_rst_no,
    output logic             tmo_flag_o
);
    localparam int NSRC  = NWAKE + 2;
    localparam int NSYNC = NSRC + 5;

    typedef struct packed {
        seq_state_e st;
        logic       flag;
    } seq_t;

    logic [NSYNC-1:0] raw, syn;
    logic s_bkup, s_osc, s_core, s_iofail, s_corefail;
    logic [NSRC-1:0] s_wake;
    logic wake_evt, tmo_hit, fail;
    seq_t r_d, r_q;

    assign raw = {alarm_i, fwake_i, wkup_i, core_fail_i, io_fail_i,
                  core_ok_i, osc_ok_i, bkup_ok_i};

    pwr_sync #(.W(NSYNC)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw),
        .q_o   (syn)
    );

    assign s_bkup     = syn[0];
    assign s_osc      = syn[1];
    assign s_core     = syn[2];
    assign s_iofail   = syn[3];
    assign s_corefail = syn[4];
    assign s_wake     = syn[NSYNC-1:5];

    pwr_wake_edge #(.W(NSRC)) u_wake (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (s_wake),
        .evt_o (wake_evt)
    );

    pwr_tmo_cnt #(.TW(TMO_W)) u_tmo (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (r_q.st == ST_START),
        .limit_i  (tmo_limit_i),
        .expired_o(tmo_hit)
    );

    assign fail = (s_iofail & io_mon_en_i) | (s_corefail & bod_en_i);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_WAIT_BKUP: if (s_bkup && s_osc) r_d.st = ST_START;
            ST_START: begin
                if (s_core) begin
                    r_d.st   = ST_RUN;
                    r_d.flag = 1'b0;
                end else if (tmo_hit) begin
                    r_d.flag = 1'b1;
                end
            end
            ST_RUN: begin
                if (fail)             r_d.st = ST_FAIL;
                else if (sleep_req_i) r_d.st = ST_BK_RST;
            end
            ST_FAIL:   if (!fail) r_d.st = ST_RUN;
            ST_BK_RST: r_d.st = ST_BK_OFF;
            ST_BK_OFF: if (wake_evt) r_d.st = ST_START;
            default:   r_d.st = ST_WAIT_BKUP;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: ST_WAIT_BKUP, flag: 1'b0};
        else         r_q <= r_d;
    end

    assign reg_en_o    = (r_q.st == ST_START) || (r_q.st == ST_RUN) ||
                         (r_q.st == ST_FAIL)  || (r_q.st == ST_BK_RST);
    assign shdn_o      = reg_en_o;
    assign sys_rst_no  = (r_q.st == ST_RUN);
    assign sub1_rst_no = 1'b0;
    assign tmo_flag_o  = r_q.flag;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic bkup_ok_i,
    input logic osc_ok_i,
    input logic reg_en_o,
    input logic shdn_o,
    input logic sys_rst_no,
    input logic tmo_flag_o
);
    AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(reg_en_o) |-> $past(bkup_ok_i, 3) && $past(osc_ok_i, 3)); // R2

    AST_RELEASE_NEEDS_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_no |-> reg_en_o && shdn_o); // R4

    AST_RELEASE_AFTER_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sys_rst_no) |-> $past(reg_en_o)); // R4

    AST_RST_BEFORE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(reg_en_o) |-> !sys_rst_no && $past(!sys_rst_no)); // R7

    AST_FLAG_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_flag_o |-> !sys_rst_no); // R9
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (.*);

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;
    localparam int NWAKE = 4;
    localparam int TMO_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bkup_ok = 0, osc_ok = 0, core_ok = 0, io_fail = 0, core_fail = 0;
    logic io_mon_en = 0, bod_en = 0, sleep_req = 0, fwake = 0, alarm = 0;
    logic [NWAKE-1:0] wkup = '0;
    logic [TMO_W-1:0] tmo_limit = 16'd10;
    logic reg_en, shdn, sys_rst_n, sub1_rst_n, tmo_flag;

    always #4 clk = ~clk;

    pwr_seq_ctrl #(.NWAKE(NWAKE), .TMO_W(TMO_W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .bkup_ok_i(bkup_ok), .osc_ok_i(osc_ok),
        .core_ok_i(core_ok), .io_fail_i(io_fail), .core_fail_i(core_fail),
        .io_mon_en_i(io_mon_en), .bod_en_i(bod_en), .sleep_req_i(sleep_req),
        .fwake_i(fwake), .wkup_i(wkup), .alarm_i(alarm), .tmo_limit_i(tmo_limit),
        .reg_en_o(reg_en), .shdn_o(shdn), .sys_rst_no(sys_rst_n),
        .sub1_rst_no(sub1_rst_n), .tmo_flag_o(tmo_flag)
    );

    typedef struct {
        string      tag;
        logic [4:0] exp;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected vector order: {reg_en, shdn, sys_rst_n, sub1_rst_n, tmo_flag}
    task automatic push(input string tag, input logic [4:0] exp);
        item_t it;
        it.tag = tag;
        it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [4:0] act;
                it = sb.pop_front();
                act = {reg_en, shdn, sys_rst_n, sub1_rst_n, tmo_flag};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic sleep_seq(input string tag);
        sleep_req = 1'b1;
        cyc(1);
        push({tag, " R7 reset first, regulator on"}, 5'b11000);
        sleep_req = 1'b0;
        core_ok = 1'b0;
        cyc(1);
        push({tag, " R7 regulator off"}, 5'b00000);
    endtask

    task automatic run_after_wake(input string tag);
        core_ok = 1'b1;
        cyc(2);
        push({tag, " R11 reset held before core ok"}, 5'b11000);
        cyc(1);
        push({tag, " R11 reset released"}, 5'b11100);
    endtask

    initial begin : driver
        cyc(2);
        push("R1 in reset", 5'b00000);
        rst_n = 1'b1;
        cyc(1);
        push("R1 after reset", 5'b00000);

        bkup_ok = 1'b1;
        cyc(6);
        push("R2 oscillator not ready", 5'b00000);
        osc_ok = 1'b1;
        cyc(2);
        push("R3 two edges not yet", 5'b00000);
        cyc(1);
        push("R3 regulator on", 5'b11000);

        cyc(20);
        push("R9 timeout flag", 5'b11001);
        core_ok = 1'b1;
        cyc(2);
        push("R4 still in reset", 5'b11001);
        cyc(1);
        push("R4 released, R9 flag clear, R8", 5'b11100);

        io_fail = 1'b1;
        cyc(6);
        push("R6 disabled monitor ignored", 5'b11100);
        io_mon_en = 1'b1;
        cyc(1);
        push("R5 io fail reset", 5'b11000);
        io_fail = 1'b0;
        cyc(2);
        push("R5 reset held", 5'b11000);
        cyc(1);
        push("R5 io fail release", 5'b11100);

        core_fail = 1'b1;
        cyc(6);
        push("R6 disabled brownout ignored", 5'b11100);
        core_fail = 1'b0;
        cyc(4);
        bod_en = 1'b1;
        core_fail = 1'b1;
        cyc(2);
        push("R5 brownout sync delay", 5'b11100);
        cyc(1);
        push("R5 brownout reset", 5'b11000);
        core_fail = 1'b0;
        cyc(3);
        push("R5 brownout release", 5'b11100);

        sleep_seq("s1");
        cyc(10);
        push("R7 stays off", 5'b00000);
        wkup[2] = 1'b1;
        cyc(2);
        push("R10 wake pin sync delay", 5'b00000);
        cyc(1);
        push("R10 R11 wake pin restart", 5'b11000);
        run_after_wake("w1");

        sleep_seq("s2");
        cyc(10);
        push("R10 held wake level ignored", 5'b00000);
        alarm = 1'b1;
        cyc(3);
        push("R10 alarm wake", 5'b11000);
        alarm = 1'b0;
        run_after_wake("w2");

        sleep_seq("s3");
        cyc(4);
        fwake = 1'b1;
        cyc(3);
        push("R10 force wake", 5'b11000);
        fwake = 1'b0;
        run_after_wake("w3");

        cyc(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule